// File: doc/BRIEF.md
# Debug-Aware Engine Freeze Controller

This block generates the freeze enables for five on-chip engines: the wakeup timer, the software timer, the radio master clock, the watchdog and the DMA. Software controls a stored freeze state through a 16-bit register port. One address sets freeze bits when a 1 is written to them. A second address clears them in the same way. Bits written as 0 leave the state alone, so two drivers can manage separate engines without a read-modify-write.

A halt indication from the processor's debug logic also freezes engines. A debug control bit selects between two behaviours. When the bit is 1, a halt stops every engine. When the bit is 0, each engine keeps following its stored bit during the halt. The watchdog is the exception and stops whenever the processor is halted. A separate control input that selects NMI-versus-reset behaviour for the watchdog blocks software from freezing the watchdog while that input is high.

Top module: `timer_freeze_ctrl`

## Requirements
- R1: After reset every stored freeze bit is 0, all five freeze outputs are 0, and the debug control bit reads back as 1.
- R2: A write to address 0x0 freezes each engine whose data bit is 1 and leaves the others unchanged. The engine bits are: 0 wakeup timer, 1 software timer, 2 radio clock, 3 watchdog, 4 DMA.
- R3: A write to address 0x2 releases each engine whose data bit is 1 and leaves the others unchanged. It uses the same bit positions as R2.
- R4: While `wdog_nmi_rst` is 1, a write to address 0x0 does not set the watchdog bit (bit 3). The other bits of that write still take effect.
- R5: While `cpu_halted` is 1 and the debug control bit is 1, all five freeze outputs are 1.
- R6: While `cpu_halted` is 1 and the debug control bit is 0, the watchdog output is 1 and each other output equals its stored bit.
- R7: While `cpu_halted` is 0, each freeze output equals its stored bit. The outputs are combinational, so they show a write from the clock edge that completes it.
- R8: A read of address 0x0 or 0x2 returns the stored freeze state in bits 4:0 and 0 in bits 15:5. A read of address 0x4 returns the debug control bit in bit 0 and 0 in bits 15:1. With `bus_sel` low, `bus_rdata` is 0.
- R9: Writes to any other address have no effect on the freeze state or on the debug control bit, and reads from those addresses return 0. Data bits 15:5 of a write to 0x0 or 0x2 are ignored.
- R10: A write to address 0x4 stores data bit 0 as the debug control bit.
- R11: A write to address 0x2 releases the watchdog whatever the value of `wdog_nmi_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| wdog_nmi_rst | input | 1 | Watchdog NMI/reset select; when 1, software cannot freeze the watchdog |
| cpu_halted | input | 1 | Processor is halted in debug |
| freeze_o | output | 5 | Freeze enables, one bit per engine as in R2 |

## Verification
A wrong stored freeze bit shows on the matching `freeze_o` pin in the first cycle after the write edge whenever the processor is running. It also shows in bits 4:0 of a read of either address. A lost or stuck debug control bit shows only while `cpu_halted` is high, and only on the non-watchdog outputs whose stored bit is 0. For that reason the bench sweeps every stored pattern against both values of the control bit and both halt levels. The watchdog guard is visible only when a set write carries bit 3 while `wdog_nmi_rst` is high, so all 32 set patterns are replayed under both values of that input.

// File: rtl/frzc_pkg.sv
package frzc_pkg;

    localparam int unsigned N_ENG = 5;

    typedef enum logic [2:0] {
        ENG_WAKEUP = 3'd0,
        ENG_SWTIM  = 3'd1,
        ENG_RADIO  = 3'd2,
        ENG_WDOG   = 3'd3,
        ENG_DMA    = 3'd4
    } engine_e;

    localparam logic [7:0] OFS_SET = 8'h00;
    localparam logic [7:0] OFS_CLR = 8'h02;
    localparam logic [7:0] OFS_DBG = 8'h04;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_STATE = 2'd1,
        RD_DBG   = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic set_we;
        logic clr_we;
        logic dbg_we;
    } wr_strobe_t;

    // Engines forced while the processor is halted.
    function automatic logic [N_ENG-1:0] halt_force(input logic dbg_en);
        logic [N_ENG-1:0] m;
        m = '0;
        m[ENG_WDOG] = 1'b1;
        if (dbg_en) m = '1;
        return m;
    endfunction

    // Bits a set write may touch.
    function automatic logic [N_ENG-1:0] set_mask(input logic nmi_sel);
        logic [N_ENG-1:0] m;
        m = '1;
        m[ENG_WDOG] = ~nmi_sel;
        return m;
    endfunction

endpackage

// File: rtl/frzc_decode.sv
module frzc_decode
    import frzc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        strobe,
    output rd_sel_e           rd_sel
);
    logic hit_set, hit_clr, hit_dbg;

    always_comb begin
        hit_set = (addr == ADDR_W'(OFS_SET));
        hit_clr = (addr == ADDR_W'(OFS_CLR));
        hit_dbg = (addr == ADDR_W'(OFS_DBG));

        strobe.set_we = sel & wr & hit_set;
        strobe.clr_we = sel & wr & hit_clr;
        strobe.dbg_we = sel & wr & hit_dbg;

        rd_sel = RD_NONE;
        if (sel && !wr) begin
            if (hit_set || hit_clr) rd_sel = RD_STATE;
            else if (hit_dbg)       rd_sel = RD_DBG;
        end
    end
endmodule

// File: rtl/frzc_state.sv
module frzc_state
    import frzc_pkg::*;
#(
    parameter int unsigned NB = N_ENG
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_strobe_t    strobe,
    input  logic [NB-1:0] wbits,
    input  logic          nmi_sel,
    output logic [NB-1:0] state
);
    logic [NB-1:0] allow;
    assign allow = set_mask(nmi_sel);

    for (genvar i = 0; i < NB; i++) begin : g_bit
        logic set_i, clr_i;
        assign set_i = strobe.set_we & wbits[i] & allow[i];
        assign clr_i = strobe.clr_we & wbits[i];
        always_ff @(posedge clk) begin
            if (rst)        state[i] <= 1'b0;
            else if (set_i) state[i] <= 1'b1;
            else if (clr_i) state[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/frzc_dbg.sv
module frzc_dbg (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic wbit,
    output logic en
);
    always_ff @(posedge clk) begin
        if (rst)     en <= 1'b1;
        else if (we) en <= wbit;
    end
endmodule

// File: rtl/frzc_out.sv
module frzc_out
    import frzc_pkg::*;
#(
    parameter int unsigned NB = N_ENG
) (
    input  logic [NB-1:0] state,
    input  logic          halted,
    input  logic          dbg_en,
    output logic [NB-1:0] frz
);
    logic [NB-1:0] force_m;
    assign force_m = halt_force(dbg_en);

    for (genvar i = 0; i < NB; i++) begin : g_eng
        assign frz[i] = state[i] | (halted & force_m[i]);
    end
endmodule

// File: rtl/timer_freeze_ctrl.sv
module timer_freeze_ctrl
    import frzc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wdog_nmi_rst,
    input  logic              cpu_halted,
    output logic [N_ENG-1:0]  freeze_o
);
    wr_strobe_t       strobe;
    rd_sel_e          rd_sel;
    logic [N_ENG-1:0] frz_state;
    logic             dbg_freeze_en;

    frzc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .strobe (strobe),
        .rd_sel (rd_sel)
    );

    frzc_state #(.NB(N_ENG)) u_state (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .wbits   (bus_wdata[N_ENG-1:0]),
        .nmi_sel (wdog_nmi_rst),
        .state   (frz_state)
    );

    frzc_dbg u_dbg (
        .clk  (clk),
        .rst  (rst),
        .we   (strobe.dbg_we),
        .wbit (bus_wdata[0]),
        .en   (dbg_freeze_en)
    );

    frzc_out #(.NB(N_ENG)) u_out (
        .state  (frz_state),
        .halted (cpu_halted),
        .dbg_en (dbg_freeze_en),
        .frz    (freeze_o)
    );

    always_comb begin
        unique case (rd_sel)
            RD_STATE: bus_rdata = DATA_W'(frz_state);
            RD_DBG:   bus_rdata = DATA_W'(dbg_freeze_en);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/timer_freeze_ctrl_checks.sv
module timer_freeze_ctrl_checks
    import frzc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wdog_nmi_rst,
    input logic              cpu_halted,
    input logic [N_ENG-1:0]  frz_state,
    input logic              dbg_freeze_en,
    input logic [N_ENG-1:0]  freeze_o
);
    logic wr_set, wr_clr;
    assign wr_set = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_SET);
    assign wr_clr = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_CLR);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (frz_state == '0 && dbg_freeze_en));

    assert_set_takes_R2: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((frz_state & $past(bus_wdata[N_ENG-1:0] & 5'b10111))
                    == $past(bus_wdata[N_ENG-1:0] & 5'b10111)));

    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((frz_state & $past(bus_wdata[N_ENG-1:0])) == '0));

    assert_wdog_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_set && wdog_nmi_rst && !frz_state[ENG_WDOG]) |=> !frz_state[ENG_WDOG]);

    assert_all_frozen_on_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_halted && dbg_freeze_en) |-> (freeze_o == '1));

    assert_wdog_frozen_on_halt_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_halted |-> freeze_o[ENG_WDOG]);

    assert_follow_state_R7: assert property (@(posedge clk) disable iff (rst)
        !cpu_halted |-> (freeze_o == frz_state));
endmodule

bind timer_freeze_ctrl timer_freeze_ctrl_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .wdog_nmi_rst  (wdog_nmi_rst),
    .cpu_halted    (cpu_halted),
    .frz_state     (frz_state),
    .dbg_freeze_en (dbg_freeze_en),
    .freeze_o      (freeze_o)
);

// File: tb/timer_freeze_ctrl_tb_top.sv
module timer_freeze_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdog_nmi_rst = 1'b0;
    logic        cpu_halted = 1'b0;
    logic [4:0]  freeze_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [4:0] m_state = '0;
    logic       m_en = 1'b1;

    always #10 clk = ~clk;

    timer_freeze_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_nmi_rst(wdog_nmi_rst), .cpu_halted(cpu_halted), .freeze_o(freeze_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic [4:0] exp_frz(input logic [4:0] st, input logic h, input logic en);
        return st | (h ? (en ? 5'h1F : 5'h08) : 5'h00);
    endfunction

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 freeze", 16'(freeze_o), 16'h0);
        rd(4'h4, r); check("R1 dbg bit", r, 16'h0001);
        rd(4'h0, r); check("R1 state", r, 16'h0000);
        check("R8 idle rdata", bus_rdata, 16'h0);

        // R2 / R4: every set pattern from empty, both guard values
        for (int nmi = 0; nmi < 2; nmi++) begin
            for (int v = 0; v < 32; v++) begin
                wr(4'h2, 16'h001F);
                wdog_nmi_rst = nmi[0];
                wr(4'h0, 16'(v));
                m_state = 5'(v) & (nmi[0] ? 5'h17 : 5'h1F);
                check(nmi[0] ? "R4 set guarded" : "R2 set", 16'(freeze_o), 16'(m_state));
                wdog_nmi_rst = 1'b0;
            end
        end

        // R2 accumulation, R3 every clear pattern from full
        wr(4'h2, 16'h001F);
        wr(4'h0, 16'h0005); wr(4'h0, 16'h0012);
        check("R2 accumulate", 16'(freeze_o), 16'h0017);
        for (int v = 0; v < 32; v++) begin
            wr(4'h0, 16'h001F);
            wr(4'h2, 16'(v));
            m_state = 5'h1F & ~5'(v);
            check("R3 clear", 16'(freeze_o), 16'(m_state));
            rd(4'h2, r); check("R8 read clr addr", r, 16'(m_state));
            rd(4'h0, r); check("R8 read set addr", r, 16'(m_state));
        end

        // R11: clear watchdog while guard high
        wr(4'h0, 16'h0008);
        wdog_nmi_rst = 1'b1;
        wr(4'h2, 16'h0008);
        m_state = 5'h00;
        check("R11 wdog release", 16'(freeze_o), 16'h0);
        wdog_nmi_rst = 1'b0;

        // R5 R6 R7 R10: all states x enable x halt
        for (int st = 0; st < 32; st++) begin
            for (int en = 0; en < 2; en++) begin
                wr(4'h2, 16'h001F);
                wr(4'h0, 16'(st));
                wr(4'h4, 16'hFFFE | 16'(en));
                m_state = 5'(st); m_en = en[0];
                rd(4'h4, r); check("R10 dbg write", r, 16'(en));
                for (int h = 0; h < 2; h++) begin
                    @(negedge clk);
                    cpu_halted = h[0];
                    #2;
                    check(h == 0 ? "R7 running" : (en == 1 ? "R5 halt all" : "R6 halt wdog"),
                          16'(freeze_o), 16'(exp_frz(m_state, h[0], m_en)));
                end
                cpu_halted = 1'b0;
            end
        end

        // R9: unmapped addresses and upper data bits
        wr(4'h2, 16'h001F); wr(4'h0, 16'h000A); wr(4'h4, 16'h0001);
        m_state = 5'h0A; m_en = 1'b1;
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 2 || a == 4) continue;
            wr(4'(a), 16'hFFFF);
            rd(4'(a), r); check("R9 unmapped read", r, 16'h0);
        end
        wr(4'h0, 16'hFFE0); wr(4'h2, 16'hFFE0);
        check("R9 state kept", 16'(freeze_o), 16'(m_state));
        rd(4'h4, r); check("R9 dbg kept", r, 16'h0001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule